// File: doc/BRIEF.md
# Opcode-Decoded 16-bit Integer ALU with Condition Flags

This block is the integer execute stage of a small console processor. Each cycle the issue logic presents an 8-bit opcode, two 16-bit operands and the current condition flags. The second operand may come from a register or from an immediate; that choice is made upstream. The block settles a 16-bit result, a destination write strobe and a new set of zero, negative, carry and overflow flags in the same cycle, with no internal storage.

The opcode byte picks the operation directly. The add, subtract, carry-chained and immediate encodings all share one adder. AND, OR, XOR, their immediate forms and bitwise NOT share one per-bit logic slice. Two operations update the flags but keep the destination unchanged: the non-destructive AND test and the compare, which subtracts and discards the difference. Any opcode outside the supported set is reported as not writing and hands the incoming flags through untouched, so another execute unit can own those encodings.

There are no states. The decode acts as a single-step selector with three named outcomes: a committed operation (WRITE), a flags-only operation (FLAGS_ONLY), or a foreign opcode (PASS). It picks the outcome from the opcode alone, in the same cycle.

Top module: `cx_alu`

## Requirements
The flag vector is 4 bits wide: bit 3 = Z, bit 2 = N, bit 1 = C, bit 0 = V. Incoming carry is `flags_i[1]`.
- R1: Opcodes 0x1E and 0x23 give result = opa + opb modulo 2^16 with write strobe high and C equal to the carry out of bit 15. The incoming carry is not used.
- R2: Opcodes 0x1F and 0x24 give result = opa - opb modulo 2^16 with write strobe high. C is the borrow, set when opa < opb as unsigned numbers.
- R3: Opcodes 0x28 and 0x30 give result = opa + opb + flags_i[1], with C equal to the carry out.
- R4: Opcodes 0x29 and 0x31 give result = opa - opb - flags_i[1]. C is set when opa < opb + flags_i[1] as unsigned numbers.
- R5: For every add, subtract, compare and chained form, V is set exactly on two's-complement signed overflow of the 16-bit operation.
- R6: For every supported opcode, Z is 1 when the 16-bit result is zero and N equals result bit 15.
- R7: Opcodes 0x32, 0x33, 0x34, 0x37 and 0x38 give AND, OR, XOR, AND and OR of opa and opb, with write strobe high and C = V = 0.
- R8: Opcode 0x35 gives result = bitwise inverse of opa with write strobe high and C = V = 0. opb has no effect.
- R9: Opcode 0x36 sets Z and N from opa AND opb and clears C and V. The write strobe is low, and result carries the AND value.
- R10: Opcodes 0x5A and 0x5B set Z, N, C and V as the subtract of R2 would, ignoring the incoming carry. The write strobe is low.
- R11: Any other opcode gives write strobe low, result 0 and flags_o equal to flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Operation byte |
| opa_i | input | 16 | Destination-side operand |
| opb_i | input | 16 | Source operand (register or immediate) |
| flags_i | input | 4 | Current flags {Z,N,C,V} |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Destination write strobe |
| flags_o | output | 4 | Next flags {Z,N,C,V} |

## Verification
The coincidence that matters is a flag update arriving together with a suppressed write. TEST and compare must produce full flags while the strobe stays low. The bench provokes this with a compare made while the incoming carry is set, and with a zero-result TEST. It judges the strobe, the result and every flag bit in the same sample. A second coincidence is a carry consumed and a signed overflow raised in one operation. Chained vectors that wrap through zero or cross the sign boundary exercise this. An opcode sweep over all 256 byte values then confirms that only the supported set writes, and that the rest pass the flags through.

// File: rtl/cx_alu_pkg.sv
package cx_alu_pkg;

    localparam int OPC_W  = 8;
    localparam int FLAG_W = 4;

    // flag bit positions inside the 4-bit flag vector
    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    // operation bytes
    localparam logic [OPC_W-1:0] OPC_ADD    = 8'h1E;
    localparam logic [OPC_W-1:0] OPC_SUB    = 8'h1F;
    localparam logic [OPC_W-1:0] OPC_ADDI   = 8'h23;
    localparam logic [OPC_W-1:0] OPC_SUBI   = 8'h24;
    localparam logic [OPC_W-1:0] OPC_ADDC   = 8'h28;
    localparam logic [OPC_W-1:0] OPC_SUBC   = 8'h29;
    localparam logic [OPC_W-1:0] OPC_ADDCI  = 8'h30;
    localparam logic [OPC_W-1:0] OPC_SUBCI  = 8'h31;
    localparam logic [OPC_W-1:0] OPC_AND    = 8'h32;
    localparam logic [OPC_W-1:0] OPC_OR     = 8'h33;
    localparam logic [OPC_W-1:0] OPC_XOR    = 8'h34;
    localparam logic [OPC_W-1:0] OPC_NOT    = 8'h35;
    localparam logic [OPC_W-1:0] OPC_TEST   = 8'h36;
    localparam logic [OPC_W-1:0] OPC_ANDI   = 8'h37;
    localparam logic [OPC_W-1:0] OPC_ORI    = 8'h38;
    localparam logic [OPC_W-1:0] OPC_CMP    = 8'h5A;
    localparam logic [OPC_W-1:0] OPC_CMPI   = 8'h5B;

    // which datapath slice produces the result
    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_ADD,
        UNIT_SUB,
        UNIT_AND,
        UNIT_OR,
        UNIT_XOR,
        UNIT_NOT
    } unit_e;

    // decode outcome
    typedef enum logic [1:0] {
        OUT_PASS,
        OUT_WRITE,
        OUT_FLAGS_ONLY
    } outcome_e;

    typedef struct packed {
        unit_e    unit;
        logic     chain;     // fold incoming carry/borrow into the adder
        outcome_e outcome;
    } ctrl_t;

endpackage

// File: rtl/cx_alu_decode.sv
module cx_alu_decode
    import cx_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl = '{unit: UNIT_NONE, chain: 1'b0, outcome: OUT_PASS};
        unique case (opcode)
            OPC_ADD, OPC_ADDI: begin
                ctrl.unit    = UNIT_ADD;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_SUB, OPC_SUBI: begin
                ctrl.unit    = UNIT_SUB;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_ADDC, OPC_ADDCI: begin
                ctrl.unit    = UNIT_ADD;
                ctrl.chain   = 1'b1;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_SUBC, OPC_SUBCI: begin
                ctrl.unit    = UNIT_SUB;
                ctrl.chain   = 1'b1;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_AND, OPC_ANDI: begin
                ctrl.unit    = UNIT_AND;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_OR, OPC_ORI: begin
                ctrl.unit    = UNIT_OR;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_XOR: begin
                ctrl.unit    = UNIT_XOR;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_NOT: begin
                ctrl.unit    = UNIT_NOT;
                ctrl.outcome = OUT_WRITE;
            end
            OPC_TEST: begin
                ctrl.unit    = UNIT_AND;
                ctrl.outcome = OUT_FLAGS_ONLY;
            end
            OPC_CMP, OPC_CMPI: begin
                ctrl.unit    = UNIT_SUB;
                ctrl.outcome = OUT_FLAGS_ONLY;
            end
            default: begin
                ctrl = '{unit: UNIT_NONE, chain: 1'b0, outcome: OUT_PASS};
            end
        endcase
    end

    // chained carry is only ever requested by an arithmetic unit
    always_comb begin
        if (ctrl.chain)
            p_chain_arith_r3: assert (ctrl.unit == UNIT_ADD || ctrl.unit == UNIT_SUB)
                else $error("chain set on a non-arithmetic unit");
    end

endmodule

// File: rtl/cx_alu_addsub.sv
module cx_alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             cin,     // carry (add) or borrow (sub) to fold in
    output logic [WIDTH-1:0] res,
    output logic             cflag,   // carry out for add, borrow out for sub
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH:0]   sum;

    // subtract as a + ~b + 1 - borrow, sharing one adder
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
        res   = sum[MSB:0];
        cflag = sub ? ~sum[WIDTH] : sum[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
    end

    always_comb begin
        if (!sub && !cin)
            p_add_carry_r1: assert (cflag == (res < a))
                else $error("carry out disagrees with wrap-around");
        if (sub && !cin)
            p_sub_borrow_r2: assert (cflag == (a < b))
                else $error("borrow disagrees with unsigned compare");
    end

endmodule

// File: rtl/cx_alu_logic.sv
module cx_alu_logic
    import cx_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  unit_e            sel,
    output logic [WIDTH-1:0] res
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            always_comb begin
                unique case (sel)
                    UNIT_AND: res[i] = a[i] & b[i];
                    UNIT_OR:  res[i] = a[i] | b[i];
                    UNIT_XOR: res[i] = a[i] ^ b[i];
                    UNIT_NOT: res[i] = ~a[i];
                    default:  res[i] = 1'b0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        if (sel == UNIT_NOT)
            p_not_invert_r8: assert ((res ^ a) == {WIDTH{1'b1}})
                else $error("inverse result does not complement opa");
    end

endmodule

// File: rtl/cx_alu_flags.sv
module cx_alu_flags
    import cx_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  ctrl_t             ctrl,
    input  logic [WIDTH-1:0]  res,
    input  logic              arith_c,
    input  logic              arith_v,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);

    logic is_arith;

    always_comb begin
        is_arith  = (ctrl.unit == UNIT_ADD) || (ctrl.unit == UNIT_SUB);
        flags_out = flags_in;
        if (ctrl.outcome != OUT_PASS) begin
            flags_out[FZ] = ~|res;
            flags_out[FN] = res[WIDTH-1];
            flags_out[FC] = is_arith ? arith_c : 1'b0;
            flags_out[FV] = is_arith ? arith_v : 1'b0;
        end
    end

endmodule

// File: rtl/cx_alu.sv
module cx_alu
    import cx_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] core_res;
    logic              arith_c;
    logic              arith_v;
    logic              is_sub;
    logic              chain_in;

    cx_alu_decode u_decode (
        .opcode (opcode_i),
        .ctrl   (ctrl)
    );

    always_comb begin
        is_sub   = (ctrl.unit == UNIT_SUB);
        chain_in = ctrl.chain & flags_i[FC];
    end

    cx_alu_addsub #(.WIDTH(DATA_W)) u_addsub (
        .a     (opa_i),
        .b     (opb_i),
        .sub   (is_sub),
        .cin   (chain_in),
        .res   (arith_res),
        .cflag (arith_c),
        .ovf   (arith_v)
    );

    cx_alu_logic #(.WIDTH(DATA_W)) u_logic (
        .a   (opa_i),
        .b   (opb_i),
        .sel (ctrl.unit),
        .res (logic_res)
    );

    always_comb begin
        unique case (ctrl.unit)
            UNIT_ADD, UNIT_SUB: core_res = arith_res;
            UNIT_NONE:          core_res = '0;
            default:            core_res = logic_res;
        endcase
    end

    cx_alu_flags #(.WIDTH(DATA_W)) u_flags (
        .ctrl      (ctrl),
        .res       (core_res),
        .arith_c   (arith_c),
        .arith_v   (arith_v),
        .flags_in  (flags_i),
        .flags_out (flags_o)
    );

    always_comb begin
        result_o = core_res;
        wr_en_o  = (ctrl.outcome == OUT_WRITE);
    end

    // checks against the top-level ports
    always_comb begin
        if (ctrl.outcome == OUT_PASS)
            p_pass_flags_r11: assert (!wr_en_o && flags_o == flags_i && result_o == '0)
                else $error("foreign opcode disturbed state");
        if (ctrl.outcome != OUT_PASS)
            p_zero_sign_r6: assert (flags_o[FZ] == (result_o == '0) && flags_o[FN] == result_o[DATA_W-1])
                else $error("Z/N disagree with result");
        if (ctrl.unit == UNIT_AND || ctrl.unit == UNIT_OR ||
            ctrl.unit == UNIT_XOR || ctrl.unit == UNIT_NOT)
            p_logic_cv_r7: assert (flags_o[FC] == 1'b0 && flags_o[FV] == 1'b0)
                else $error("logic op left C or V set");
        if (opcode_i == OPC_TEST || opcode_i == OPC_CMP || opcode_i == OPC_CMPI)
            p_flags_only_r10: assert (!wr_en_o)
                else $error("flags-only op raised the write strobe");
    end

endmodule

// File: tb/cx_alu_tb_top.sv
module cx_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode;
    logic [15:0] opa;
    logic [15:0] opb;
    logic [3:0]  fin;
    logic [15:0] result;
    logic        wr_en;
    logic [3:0]  fout;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cx_alu dut_i (
        .opcode_i (opcode),
        .opa_i    (opa),
        .opb_i    (opb),
        .flags_i  (fin),
        .result_o (result),
        .wr_en_o  (wr_en),
        .flags_o  (fout)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [3:0]  fi;
        logic [15:0] res;
        logic        wr;
        logic [3:0]  fo;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 21;
    // flags {Z,N,C,V}
    localparam vec_t VEC [NV] = '{
        '{8'h1E, 16'h0001, 16'h0002, 4'h2, 16'h0003, 1'b1, 4'h0, 4'd1 },  // R1 carry in ignored
        '{8'h1E, 16'hFFFF, 16'h0001, 4'h0, 16'h0000, 1'b1, 4'hA, 4'd1 },  // R1 wrap, carry out
        '{8'h23, 16'h7FFF, 16'h0001, 4'h0, 16'h8000, 1'b1, 4'h5, 4'd5 },  // R5 signed overflow add
        '{8'h1F, 16'h0005, 16'h0007, 4'h0, 16'hFFFE, 1'b1, 4'h6, 4'd2 },  // R2 borrow
        '{8'h24, 16'h8000, 16'h0001, 4'h0, 16'h7FFF, 1'b1, 4'h1, 4'd5 },  // R5 signed overflow sub
        '{8'h28, 16'h00FF, 16'h0001, 4'h2, 16'h0101, 1'b1, 4'h0, 4'd3 },  // R3 carry folded in
        '{8'h30, 16'hFFFF, 16'h0000, 4'h2, 16'h0000, 1'b1, 4'hA, 4'd3 },  // R3 carry wraps to zero
        '{8'h29, 16'h0005, 16'h0005, 4'h2, 16'hFFFF, 1'b1, 4'h6, 4'd4 },  // R4 borrow folded in
        '{8'h31, 16'h1234, 16'h0034, 4'h0, 16'h1200, 1'b1, 4'h0, 4'd4 },  // R4 no borrow
        '{8'h32, 16'hF0F0, 16'h0FF0, 4'hF, 16'h00F0, 1'b1, 4'h0, 4'd7 },  // R7 AND clears C,V
        '{8'h33, 16'h8000, 16'h0001, 4'h0, 16'h8001, 1'b1, 4'h4, 4'd7 },  // R7 OR
        '{8'h34, 16'hAAAA, 16'hAAAA, 4'h0, 16'h0000, 1'b1, 4'h8, 4'd6 },  // R6 XOR to zero
        '{8'h35, 16'h00FF, 16'h1234, 4'h3, 16'hFF00, 1'b1, 4'h4, 4'd8 },  // R8 NOT
        '{8'h35, 16'h0000, 16'hFFFF, 4'h0, 16'hFFFF, 1'b1, 4'h4, 4'd8 },  // R8 opb no effect
        '{8'h36, 16'h00F0, 16'h0F00, 4'h3, 16'h0000, 1'b0, 4'h8, 4'd9 },  // R9 TEST zero
        '{8'h37, 16'h1234, 16'h00FF, 4'h0, 16'h0034, 1'b1, 4'h0, 4'd7 },  // R7 AND imm
        '{8'h38, 16'h0000, 16'h0000, 4'h3, 16'h0000, 1'b1, 4'h8, 4'd7 },  // R7 OR imm
        '{8'h5A, 16'h0003, 16'h0003, 4'h2, 16'h0000, 1'b0, 4'h8, 4'd10},  // R10 CMP equal, carry ignored
        '{8'h5B, 16'h0001, 16'h0002, 4'h0, 16'hFFFF, 1'b0, 4'h6, 4'd10},  // R10 CMP imm less
        '{8'h20, 16'h0005, 16'h0006, 4'hB, 16'h0000, 1'b0, 4'hB, 4'd11},  // R11 foreign op
        '{8'hFF, 16'h1111, 16'h2222, 4'h5, 16'h0000, 1'b0, 4'h5, 4'd11}   // R11 foreign op
    };

    function automatic bit supported(input logic [7:0] op);
        case (op)
            8'h1E, 8'h1F, 8'h23, 8'h24, 8'h28, 8'h29, 8'h30, 8'h31,
            8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38,
            8'h5A, 8'h5B: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    task automatic apply(input logic [7:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [3:0] f);
        @(posedge clk);
        opcode = op;
        opa    = a;
        opb    = b;
        fin    = f;
        @(negedge clk);
    endtask

    task automatic expect_all(input string req, input logic [15:0] er,
                              input logic ew, input logic [3:0] ef);
        n_checks++;
        if (result !== er || wr_en !== ew || fout !== ef) begin
            n_fails++;
            $display("FAIL %s op=%02h: got res=%04h wr=%0b fl=%01h, expected res=%04h wr=%0b fl=%01h",
                     req, opcode, result, wr_en, fout, er, ew, ef);
        end
    endtask

    initial begin
        opcode = 8'h00;
        opa    = 16'h0000;
        opb    = 16'h0000;
        fin    = 4'h9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: idle opcode 0x00 is foreign (R11)
        expect_all("R11 reset", 16'h0000, 1'b0, 4'h9);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].fi);
            expect_all($sformatf("R%0d vec%0d", VEC[i].tag, i), VEC[i].res, VEC[i].wr, VEC[i].fo);
        end

        // opcode sweep: write strobe only for supported writers, R9 R10 R11
        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            bit         wexp;
            o    = op[7:0];
            wexp = supported(o) && o != 8'h36 && o != 8'h5A && o != 8'h5B;
            apply(o, 16'h8421, 16'h1248, 4'h6);
            n_checks++;
            if (wr_en !== wexp || (!supported(o) && (fout !== 4'h6 || result !== 16'h0000))) begin
                n_fails++;
                $display("FAIL R11 sweep op=%02h: got wr=%0b fl=%01h res=%04h, expected wr=%0b",
                         o, wr_en, fout, result, wexp);
            end
        end

        // chained subtract crossing sign boundary with borrow: R4 R5
        apply(8'h29, 16'h8000, 16'h0000, 4'h2);
        expect_all("R4 R5 chained overflow", 16'h7FFF, 1'b1, 4'h1);
        // chained add whose carry creates signed overflow: R3 R5
        apply(8'h28, 16'h7FFF, 16'h0000, 4'h2);
        expect_all("R3 R5 chained overflow", 16'h8000, 1'b1, 4'h5);
        // compare with negative result and overflow: R10 R5
        apply(8'h5A, 16'h8000, 16'h0001, 4'h0);
        expect_all("R10 R5 cmp overflow", 16'h7FFF, 1'b0, 4'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule